// File: doc/BRIEF.md
# Multi-Channel Interrupt Aggregator with Periodic Tick

This block gathers level interrupt requests from up to four groups of eight serial channels and reduces them to one host interrupt line. Each group's requests are visible as one status byte, one bit per channel. A separate summary byte shows which groups have any request pending.

The host programs a control byte. It holds one enable bit per group, a periodic tick rate and a mode in which only ticks reach the host. A command write carries the global host enable and an end-of-interrupt strobe.

The host line is a sticky level. Any unmasked event sets it. It stays set until the host strobes end-of-interrupt or turns the global enable off. An event that arrives in the same cycle as the strobe is not lost. The tick rates come from a free-running power-of-two divider on the system clock. Each step up in rate code halves the period.

Top module: `irq_aggregator`

## Requirements
- R1: `grp_status_o` bit `8*g+n` is set while channel n of group g requests, one clock edge after `chan_irq_i` shows the request. All bits are 0 out of reset.
- R2: `ctrl_status_o` bit g (g below NUM_GRP) is the OR of group g's registered requests, whatever the group enables are. Bits NUM_GRP to 7 are always 0.
- R3: A command write with bit 0 clear turns the host enable off. `irq_o` is low from the edge that takes that write and stays low while the enable is off, even with requests present.
- R4: A command write with bit 1 set is the end-of-interrupt strobe. When no event is present in that cycle, `irq_o` is low after the edge that takes it.
- R5: Control bits 3:0 enable groups 0 to 3. Requests from a disabled group never raise `irq_o`.
- R6: Control bits 6:4 hold a rate code k. For k from 1 to 6, a tick occurs every 2^(TICK_LOG2+1-k) cycles. The tick falls in cycles where the number of edges since reset, taken modulo that period, equals the period minus 1, and it is latched at the following edge. Codes 0 and 7 give no ticks.
- R7: With control bit 7 set, channel requests are ignored and only ticks raise `irq_o`.
- R8: Once set, `irq_o` stays high until a strobe or a disable, even after its source has gone away.
- R9: An event present in the same cycle as the strobe keeps `irq_o` asserted, with the host still enabled.
- R10: A request presented before edge 1 is registered at edge 1. It sets `irq_o` at edge 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chan_irq_i | input | NUM_GRP*CH_PER_GRP | Level requests, channel n of group g at bit 8*g+n |
| ctrl_we_i | input | 1 | Control byte write strobe |
| ctrl_wdata_i | input | 8 | Control byte: [7] tick only, [6:4] rate, [3:0] group enables |
| cmd_we_i | input | 1 | Command write strobe |
| cmd_wdata_i | input | 2 | Command: [0] host enable, [1] end-of-interrupt |
| grp_status_o | output | NUM_GRP*CH_PER_GRP | Per-group channel request bytes |
| ctrl_status_o | output | 8 | Groups with a pending request, upper bits zero |
| irq_o | output | 1 | Host interrupt level |

## Verification
A wrong latch state shows at `irq_o` in one of three ways. The line can stay high after a strobe when no event is present. It can drop while no strobe or disable was written. It can fail to rise two edges after an enabled request. Each of these is visible within one or two cycles.

A divider fault shows as a wrong distance between two tick-driven rises, measured for every rate code. It also shows as rises with codes 0 or 7, and as a wrong tick phase against the edge count during the random run. A corrupted input register shows at once in the group status bytes and in the summary byte.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  typedef struct packed {
    logic       tick_only;
    logic [2:0] rate;
    logic [3:0] grp_en;
  } agg_ctrl_t;

  localparam int MAX_GRP    = 4;
  localparam int RATE_CODES = 8;
endpackage

// File: rtl/irq_tick_gen.sv
module irq_tick_gen #(
  parameter int TICK_LOG2 = 22
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] rate_i,
  output logic       tick_o
);
  localparam int CW = TICK_LOG2;

  logic [CW-1:0] cnt_q;
  logic [irq_agg_pkg::RATE_CODES-1:0] tap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + CW'(1);
  end

  // code k fires when the low CW+1-k bits are all ones
  assign tap[0] = 1'b0;
  assign tap[7] = 1'b0;
  for (genvar k = 1; k <= 6; k++) begin : g_tap
    assign tap[k] = &cnt_q[CW-k:0];
  end

  assign tick_o = tap[rate_i];
endmodule

// File: rtl/irq_grp_sum.sv
module irq_grp_sum #(
  parameter int NUM_GRP    = 4,
  parameter int CH_PER_GRP = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_GRP*CH_PER_GRP-1:0] chan_i,
  input  logic [NUM_GRP-1:0]            grp_en_i,
  output logic [NUM_GRP*CH_PER_GRP-1:0] status_o,
  output logic [NUM_GRP-1:0]            grp_any_o,
  output logic                          chan_hit_o
);
  localparam int NCH = NUM_GRP * CH_PER_GRP;

  logic [NCH-1:0] chan_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chan_q <= '0;
    else         chan_q <= chan_i;
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    assign grp_any_o[g] = |chan_q[g*CH_PER_GRP +: CH_PER_GRP];
  end

  assign status_o   = chan_q;
  assign chan_hit_o = |(grp_any_o & grp_en_i);
endmodule

// File: rtl/irq_line_latch.sv
module irq_line_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic eoi_i,
  input  logic en_nxt_i,
  output logic irq_o
);
  logic irq_q;

  // new event wins over the strobe; disable wins over everything
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= en_nxt_i & ((irq_q & ~eoi_i) | evt_i);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int NUM_GRP    = 4,
  parameter int CH_PER_GRP = 8,
  parameter int TICK_LOG2  = 22
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_GRP*CH_PER_GRP-1:0] chan_irq_i,
  input  logic                          ctrl_we_i,
  input  logic [7:0]                    ctrl_wdata_i,
  input  logic                          cmd_we_i,
  input  logic [1:0]                    cmd_wdata_i,
  output logic [NUM_GRP*CH_PER_GRP-1:0] grp_status_o,
  output logic [7:0]                    ctrl_status_o,
  output logic                          irq_o
);
  localparam int PAD = 8 - NUM_GRP;

  agg_ctrl_t          ctrl_q;
  logic               host_en_q;
  logic               host_en_nxt;
  logic               eoi_c;
  logic               tick_c;
  logic               chan_hit_c;
  logic               evt_c;
  logic [NUM_GRP-1:0] grp_any;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= '0;
    else if (ctrl_we_i) ctrl_q <= agg_ctrl_t'(ctrl_wdata_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) host_en_q <= 1'b0;
    else         host_en_q <= host_en_nxt;
  end

  assign host_en_nxt = cmd_we_i ? cmd_wdata_i[0] : host_en_q;
  assign eoi_c       = cmd_we_i & cmd_wdata_i[1];

  irq_tick_gen #(.TICK_LOG2(TICK_LOG2)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rate_i (ctrl_q.rate),
    .tick_o (tick_c)
  );

  irq_grp_sum #(.NUM_GRP(NUM_GRP), .CH_PER_GRP(CH_PER_GRP)) u_grp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .chan_i     (chan_irq_i),
    .grp_en_i   (ctrl_q.grp_en[NUM_GRP-1:0]),
    .status_o   (grp_status_o),
    .grp_any_o  (grp_any),
    .chan_hit_o (chan_hit_c)
  );

  assign evt_c = tick_c | (~ctrl_q.tick_only & chan_hit_c);

  irq_line_latch u_line (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt_c),
    .eoi_i    (eoi_c),
    .en_nxt_i (host_en_nxt),
    .irq_o    (irq_o)
  );

  assign ctrl_status_o = {{PAD{1'b0}}, grp_any};
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
  parameter int NUM_GRP = 4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_we_i,
  input logic [1:0] cmd_wdata_i,
  input logic       tick_only_i,
  input logic       tick_i,
  input logic       evt_i,
  input logic [7:0] ctrl_status_i,
  input logic       irq_i
);
  AST_CSTAT_HI_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_status_i >> NUM_GRP) == 8'd0); // R2

  AST_DISABLE_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && !cmd_wdata_i[0]) |=> !irq_i); // R3

  AST_EOI_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && cmd_wdata_i[1] && !evt_i) |=> !irq_i); // R4

  AST_TICK_ONLY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_only_i && !tick_i && !irq_i) |=> !irq_i); // R7

  AST_LEVEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && !cmd_we_i) |=> irq_i); // R8

  AST_EOI_RACE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && cmd_wdata_i[1] && cmd_wdata_i[0] && evt_i) |=> irq_i); // R9
endmodule

bind irq_aggregator irq_aggregator_chk #(.NUM_GRP(NUM_GRP)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cmd_we_i      (cmd_we_i),
  .cmd_wdata_i   (cmd_wdata_i),
  .tick_only_i   (ctrl_q.tick_only),
  .tick_i        (tick_c),
  .evt_i         (evt_c),
  .ctrl_status_i (ctrl_status_o),
  .irq_i         (irq_o)
);

// File: tb/irq_aggregator_bench.sv
`timescale 1ns/1ps
module irq_aggregator_bench;
  localparam int NG = 4;
  localparam int CH = 8;
  localparam int TL = 8;
  localparam int NC = NG * CH;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NC-1:0] chan = '0;
  logic          ctrl_we = 1'b0;
  logic [7:0]    ctrl_wd = '0;
  logic          cmd_we = 1'b0;
  logic [1:0]    cmd_wd = '0;
  logic [NC-1:0] grp_status;
  logic [7:0]    ctrl_status;
  logic          irq;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  irq_aggregator #(.NUM_GRP(NG), .CH_PER_GRP(CH), .TICK_LOG2(TL)) u_irq_aggregator (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .chan_irq_i    (chan),
    .ctrl_we_i     (ctrl_we),
    .ctrl_wdata_i  (ctrl_wd),
    .cmd_we_i      (cmd_we),
    .cmd_wdata_i   (cmd_wd),
    .grp_status_o  (grp_status),
    .ctrl_status_o (ctrl_status),
    .irq_o         (irq)
  );

  // reference model built from the requirements
  logic [NC-1:0] m_chq;
  logic [7:0]    m_ctrl;
  logic          m_en;
  logic          m_irq;
  int unsigned   m_cnt;

  function automatic logic m_tick(input logic [2:0] r, input int unsigned c);
    int unsigned p;
    if (r == 3'd0 || r == 3'd7) return 1'b0;
    p = 32'd1 << (TL + 1 - int'(r));
    return (c % p) == p - 1;
  endfunction

  function automatic logic [7:0] m_any(input logic [NC-1:0] q);
    logic [7:0] a;
    a = '0;
    for (int g = 0; g < NG; g++) a[g] = |q[g*CH +: CH];
    return a;
  endfunction

  always @(posedge clk) begin
    logic evt;
    logic en_n;
    if (!rst_ni) begin
      m_chq = '0; m_ctrl = '0; m_en = 1'b0; m_irq = 1'b0; m_cnt = 0;
    end else begin
      evt   = m_tick(m_ctrl[6:4], m_cnt) | (!m_ctrl[7] & |(m_any(m_chq) & m_ctrl[7:0] & 8'h0F));
      en_n  = cmd_we ? cmd_wd[0] : m_en;
      m_irq = en_n & ((m_irq & !(cmd_we & cmd_wd[1])) | evt);
      m_en  = en_n;
      if (ctrl_we) m_ctrl = ctrl_wd;
      m_chq = chan;
      m_cnt = m_cnt + 1;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    ctrl_we = 1'b1; ctrl_wd = v;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic wr_cmd(input logic [1:0] v);
    cmd_we = 1'b1; cmd_wd = v;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  // wait for a rise, clear it, return cycles from the clear to the next rise
  task automatic tick_gap(output int n);
    int w;
    w = 0;
    while (!irq && w < 700) begin @(negedge clk); w++; end
    wr_cmd(2'b11);
    n = 1;
    while (!irq && n < 700) begin @(negedge clk); n++; end
  endtask

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int gap;
    void'($urandom(32'd4711));
    step(3);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 reset status", 64'(grp_status), 64'd0);
    chk("R2 reset summary", 64'(ctrl_status), 64'd0);
    chk("R8 reset line", 64'(irq), 64'd0);

    wr_cmd(2'b01);
    wr_ctrl(8'h0F);
    chan = NC'(1) << 11;
    @(negedge clk);
    chk("R1 status bit 11", 64'(grp_status), 64'(NC'(1) << 11));
    chk("R2 group 1 pending", 64'(ctrl_status), 64'h02);
    chk("R10 not yet after edge 1", 64'(irq), 64'd0);
    @(negedge clk);
    chk("R10 set at edge 2", 64'(irq), 64'd1);
    chan = '0;
    step(3);
    chk("R8 held after source gone", 64'(irq), 64'd1);
    chk("R1 status cleared", 64'(grp_status), 64'd0);
    wr_cmd(2'b11);
    chk("R4 strobe clears", 64'(irq), 64'd0);

    chan = NC'(1) << 20;
    step(2);
    chk("R10 group 2 request", 64'(irq), 64'd1);
    wr_cmd(2'b11);
    chk("R9 event with strobe kept", 64'(irq), 64'd1);
    chan = '0;
    step(2);
    wr_cmd(2'b11);
    chk("R4 strobe clears after race", 64'(irq), 64'd0);

    wr_ctrl(8'h0E);
    chan = NC'(32'h0000_00FF);
    step(4);
    chk("R5 disabled group 0 masked", 64'(irq), 64'd0);
    chk("R2 summary ignores enables", 64'(ctrl_status), 64'h01);
    chan = '0;
    step(2);

    wr_ctrl(8'h8F);
    chan = '1;
    step(4);
    chk("R7 tick-only ignores channels", 64'(irq), 64'd0);
    chk("R2 all groups pending", 64'(ctrl_status), 64'h0F);
    chan = '0;
    step(2);

    wr_ctrl(8'h0F);
    chan = NC'(1) << 5;
    step(2);
    chk("R10 group 0 request", 64'(irq), 64'd1);
    wr_cmd(2'b00);
    chk("R3 disable drops line", 64'(irq), 64'd0);
    step(3);
    chk("R3 stays low with request", 64'(irq), 64'd0);
    wr_cmd(2'b01);
    chan = '0;
    step(2);
    wr_cmd(2'b11);
    chk("R4 clear after re-enable", 64'(irq), 64'd0);

    for (int r = 1; r <= 6; r++) begin
      wr_ctrl(8'h80 | 8'(r << 4));
      tick_gap(gap);
      tick_gap(gap);
      chk($sformatf("R6 period code %0d", r), 64'(gap), 64'(1 << (TL + 1 - r)));
    end
    wr_ctrl(8'h80);
    wr_cmd(2'b11);
    step(600);
    chk("R6 code 0 silent", 64'(irq), 64'd0);
    wr_ctrl(8'hF0);
    wr_cmd(2'b11);
    step(600);
    chk("R6 code 7 silent", 64'(irq), 64'd0);

    for (int i = 0; i < 3000; i++) begin
      chk("R5 random line vs model", 64'(irq), 64'(m_irq));
      chk("R1 random status vs model", 64'(grp_status), 64'(m_chq));
      chk("R2 random summary vs model", 64'(ctrl_status), 64'(m_any(m_chq)));
      if ($urandom % 4 == 0) chan = ($urandom % 3 == 0) ? NC'($urandom) : '0;
      ctrl_we = ($urandom % 16 == 0);
      ctrl_wd = 8'($urandom);
      cmd_we  = ($urandom % 6 == 0);
      cmd_wd  = {1'($urandom), 1'($urandom % 8 != 0)};
      @(negedge clk);
    end
    ctrl_we = 1'b0;
    cmd_we  = 1'b0;
    finish_run();
  end
endmodule